// File: doc/BRIEF.md
# Generalized Reverse Butterfly Unit

This block permutes or combines the bits of a 64-bit operand through a six-row butterfly network. Each row pairs every bit with the bit whose index differs only in that row's position, so the rows work on groups of 1, 2, 4, 8, 16 and 32 bits. A row takes part when the matching bit of the control amount is set. It applies to every pair in that row or to none of them. There is no setting for individual pairs.

There are three ways to combine a pair. The swap mode exchanges the two bits. The OR mode gives each bit the OR of itself and its partner. The lookup mode passes each pair through a 2-input truth table taken from an 8-bit immediate. Because of the lookup mode, the same datapath can also produce regular 64-bit constant patterns. A word-width select confines the operation to the low 32 bits.

The result is captured in one output register, so it appears one clock edge after the operands are presented.

Top module: `grevbfly_top`

## Requirements
- R1: While the active-low reset is asserted, the result register clears to zero.
- R2: The result for a set of inputs appears at the first rising clock edge after those inputs are applied. Before that edge the result keeps its previous value.
- R3: With a control amount of zero, the input passes through unchanged in every mode. In word mode, the low 32 bits pass through and the upper 32 result bits are zero.
- R4: Swap mode (mode code 2'b00): a row for group size N = 2^k is active when amount bit k is set. An active row exchanges every N-bit group with its neighbouring group. Active rows apply in order of increasing N. An amount of 63 therefore reverses all 64 bits, and an amount of 56 reverses the byte order.
- R5: OR mode (mode code 2'b01): an active row replaces each bit with the OR of itself and its partner bit. The row order is the same as in R4.
- R6: Lookup mode (mode code 2'b10): in an active row of size N, result bit j is entry {x[j^N], x[j]} of a 4-bit truth table. Entry 0 is the table's LSB. The table is imm[3:0] when (j & N) == 0 and imm[7:4] otherwise. The row order is the same as in R4.
- R7: Mode code 2'b11 behaves exactly like swap mode.
- R8: Word mode (wordMode = 1) ignores amount bit 5. In word mode, only bits 31..0 of the input take part, and result bits 63..32 are zero.
- R9: Setting the immediate to 8'hCC in lookup mode reproduces swap mode, and 8'hEE reproduces OR mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset; clears the result register |
| opMode | input | 2 | 00 swap, 01 OR, 10 lookup, 11 same as swap |
| wordMode | input | 1 | 1 selects 32-bit operation |
| ctrlAmt | input | 6 | Row enable amount; bit k enables the row of size 2^k |
| lutImm | input | 8 | Two 4-bit truth tables for lookup mode |
| dataIn | input | 64 | Operand |
| result | output | 64 | Registered result |

## Verification
Every result of this block is due exactly one rising edge after its operands are applied. The bench changes the operands on a falling edge. A short moment later it confirms that the result still holds the previous value. It then compares the result at the next falling edge, half a period after the capturing edge. Each vector takes two falling edges, so a result is never compared in the same cycle its operands change.

// File: rtl/grevbfly_pkg.sv
package grevbfly_pkg;
  localparam int BF_DATA_W = 64;
  localparam int BF_STAGES = $clog2(BF_DATA_W);
  localparam int BF_HALF_W = BF_DATA_W / 2;
  localparam int BF_IMM_W  = 8;

  typedef enum logic [1:0] {
    MODE_SWAP = 2'b00,
    MODE_ORC  = 2'b01,
    MODE_LUT  = 2'b10,
    MODE_ALT  = 2'b11
  } bflyMode_e;

  typedef struct packed {
    logic [BF_STAGES-1:0] stageEn;
    logic                 orSel;
    logic                 lutSel;
    logic                 clearHigh;
  } bflyStrobe_t;
endpackage

// File: rtl/grevbfly_ctrl.sv
module grevbfly_ctrl
  import grevbfly_pkg::*;
(
  input  logic [1:0]           opMode,
  input  logic                 wordMode,
  input  logic [BF_STAGES-1:0] ctrlAmt,
  output bflyStrobe_t          strobes
);
  always_comb begin
    strobes.stageEn   = ctrlAmt;
    if (wordMode) strobes.stageEn[BF_STAGES-1] = 1'b0;
    strobes.orSel     = (opMode == MODE_ORC);
    strobes.lutSel    = (opMode == MODE_LUT);
    strobes.clearHigh = wordMode;
  end
endmodule

// File: rtl/grevbfly_dp.sv
module grevbfly_dp
  import grevbfly_pkg::*;
(
  input  bflyStrobe_t          strobes,
  input  logic [BF_IMM_W-1:0]  lutImm,
  input  logic [BF_DATA_W-1:0] dataIn,
  output logic [BF_DATA_W-1:0] dataOut
);
  localparam int NIB_W = BF_IMM_W / 2;

  logic [BF_STAGES:0][BF_DATA_W-1:0] stageVal;

  assign stageVal[0] = strobes.clearHigh ?
                       {{BF_HALF_W{1'b0}}, dataIn[BF_HALF_W-1:0]} : dataIn;

  for (genvar k = 0; k < BF_STAGES; k++) begin : g_row
    localparam int CHUNK = 1 << k;
    for (genvar j = 0; j < BF_DATA_W; j++) begin : g_bit
      localparam int PART = j ^ CHUNK;
      localparam int HI   = (j >> k) & 1;
      logic             selfBit;
      logic             partBit;
      logic [NIB_W-1:0] table4;
      logic             lutBit;
      logic             nextBit;
      always_comb begin
        selfBit = stageVal[k][j];
        partBit = stageVal[k][PART];
        table4  = (HI != 0) ? lutImm[BF_IMM_W-1:NIB_W] : lutImm[NIB_W-1:0];
        lutBit  = table4[{partBit, selfBit}];
        if (strobes.lutSel)     nextBit = lutBit;
        else if (strobes.orSel) nextBit = selfBit | partBit;
        else                    nextBit = partBit;
      end
      assign stageVal[k+1][j] = strobes.stageEn[k] ? nextBit : selfBit;
    end
  end

  assign dataOut = strobes.clearHigh ?
                   {{BF_HALF_W{1'b0}}, stageVal[BF_STAGES][BF_HALF_W-1:0]} :
                   stageVal[BF_STAGES];
endmodule

// File: rtl/grevbfly_top.sv
module grevbfly_top
  import grevbfly_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [1:0]           opMode,
  input  logic                 wordMode,
  input  logic [BF_STAGES-1:0] ctrlAmt,
  input  logic [BF_IMM_W-1:0]  lutImm,
  input  logic [BF_DATA_W-1:0] dataIn,
  output logic [BF_DATA_W-1:0] result
);
  bflyStrobe_t          strobes;
  logic [BF_DATA_W-1:0] dpOut;

  grevbfly_ctrl ctrl_i (
    .opMode   (opMode),
    .wordMode (wordMode),
    .ctrlAmt  (ctrlAmt),
    .strobes  (strobes)
  );

  grevbfly_dp dp_i (
    .strobes (strobes),
    .lutImm  (lutImm),
    .dataIn  (dataIn),
    .dataOut (dpOut)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) result <= '0;
    else       result <= dpOut;
  end
endmodule

// File: rtl/grevbfly_chk.sv
module grevbfly_chk
  import grevbfly_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic [1:0]           opMode,
  input logic                 wordMode,
  input logic [BF_STAGES-1:0] ctrlAmt,
  input logic [BF_DATA_W-1:0] dataIn,
  input logic [BF_DATA_W-1:0] result
);
  logic lowSeen;
  always_ff @(posedge clk) lowSeen <= !rstN;

  // R1
  always @(posedge clk) begin
    if (lowSeen === 1'b1 && rstN === 1'b0)
      reset_clear_chk: assert (result == '0);
  end

  // R3
  passthru_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlAmt == '0 && !wordMode) |=> (result == $past(dataIn)));

  // R3
  passthru_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlAmt[BF_STAGES-2:0] == '0 && wordMode) |=>
      (result == {{BF_HALF_W{1'b0}}, $past(dataIn[BF_HALF_W-1:0])}));

  // R8
  word_high_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    wordMode |=> (result[BF_DATA_W-1:BF_HALF_W] == '0));

  // R4
  swap_popcount_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opMode == MODE_SWAP && !wordMode) |=>
      ($countones(result) == $countones($past(dataIn))));

  // R5
  orc_superset_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opMode == MODE_ORC && !wordMode) |=>
      ((result & $past(dataIn)) == $past(dataIn)));
endmodule

bind grevbfly_top grevbfly_chk chk_i (.*);

// File: tb/grevbfly_tb.sv
module grevbfly_top_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  opMode = 2'b00;
  logic        wordMode = 1'b0;
  logic [5:0]  ctrlAmt = '0;
  logic [7:0]  lutImm = '0;
  logic [63:0] dataIn = '0;
  logic [63:0] result;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  grevbfly_top dut_i (
    .clk(clk), .rstN(rstN), .opMode(opMode), .wordMode(wordMode),
    .ctrlAmt(ctrlAmt), .lutImm(lutImm), .dataIn(dataIn), .result(result)
  );

  function automatic logic [63:0] refCalc(logic [1:0] m, logic w, logic [5:0] a,
                                          logic [7:0] imm, logic [63:0] d);
    logic [63:0] x;
    logic [63:0] y;
    logic [5:0]  amt;
    x   = w ? {32'h0, d[31:0]} : d;
    amt = w ? {1'b0, a[4:0]} : a;
    for (int k = 0; k < 6; k++) begin
      if (amt[k]) begin
        for (int j = 0; j < 64; j++) begin
          logic p;
          logic s;
          int idx;
          s = x[j];
          p = x[j ^ (1 << k)];
          idx = (((j >> k) & 1) * 4) + (p ? 2 : 0) + (s ? 1 : 0);
          case (m)
            2'b01:   y[j] = s | p;
            2'b10:   y[j] = imm[idx];
            default: y[j] = p;
          endcase
        end
        x = y;
      end
    end
    if (w) x[63:32] = '0;
    return x;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(string req, logic [1:0] m, logic w, logic [5:0] a,
                       logic [7:0] imm, logic [63:0] d, logic [63:0] exp);
    logic [63:0] prev;
    @(negedge clk);
    prev = result;
    opMode = m; wordMode = w; ctrlAmt = a; lutImm = imm; dataIn = d;
    #1;
    check("R2 hold", result, prev);
    @(negedge clk);
    check(req, result, exp);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [63:0] d;
    logic [5:0]  a;
    logic [7:0]  imm;
    logic [1:0]  m;
    logic        w;
    void'($urandom(32'd1207));
    dataIn = 64'hDEAD_BEEF_0123_4567;
    ctrlAmt = 6'h3F;
    repeat (3) @(negedge clk);
    check("R1 reset", result, 64'h0);
    rstN = 1'b1;

    // R3 zero amount passes through in every mode
    d = 64'hA5C3_0F1E_7788_1234;
    apply("R3 swap", 2'b00, 1'b0, 6'd0, 8'h00, d, d);
    apply("R3 orc", 2'b01, 1'b0, 6'd0, 8'h00, d, d);
    apply("R3 lut", 2'b10, 1'b0, 6'd0, 8'h00, d, d);
    apply("R3 word", 2'b10, 1'b1, 6'd0, 8'h00, d, {32'h0, d[31:0]});
    // R4 full reverse and byte reverse
    apply("R4 rev", 2'b00, 1'b0, 6'h3F, 8'h00, 64'h1, 64'h8000_0000_0000_0000);
    apply("R4 bswap", 2'b00, 1'b0, 6'd56, 8'h00, 64'h0102_0304_0506_0708,
          64'h0807_0605_0403_0201);
    apply("R4 nibble", 2'b00, 1'b0, 6'd4, 8'h00, 64'h0000_0000_0000_00A5,
          64'h0000_0000_0000_005A);
    // R5 OR-combine
    apply("R5 orc7", 2'b01, 1'b0, 6'd7, 8'h00, 64'h10, 64'hFF);
    apply("R5 orc63", 2'b01, 1'b0, 6'h3F, 8'h00, 64'h1 << 40, {64{1'b1}});
    // R6 lookup tables by half
    apply("R6 lowtab", 2'b10, 1'b0, 6'd1, 8'h0F, 64'h0, 64'h5555_5555_5555_5555);
    apply("R6 hightab", 2'b10, 1'b0, 6'd2, 8'hF0, 64'h0, 64'hCCCC_CCCC_CCCC_CCCC);
    apply("R6 ident", 2'b10, 1'b0, 6'h3F, 8'hAA, d, d);
    // R7 reserved code acts as swap
    apply("R7 alt", 2'b11, 1'b0, 6'h3F, 8'h00, 64'h1, 64'h8000_0000_0000_0000);
    // R8 word mode
    apply("R8 wrev", 2'b00, 1'b1, 6'd31, 8'h00, 64'hFFFF_0000_0000_0001, 64'h8000_0000);
    apply("R8 bit5", 2'b00, 1'b1, 6'd63, 8'h00, 64'hFFFF_0000_0000_0001, 64'h8000_0000);
    apply("R8 lutz", 2'b10, 1'b1, 6'd1, 8'hFF, 64'h0, 64'hFFFF_FFFF);
    // R9 immediate equivalences
    apply("R9 ccswap", 2'b10, 1'b0, 6'd45, 8'hCC, d, refCalc(2'b00, 1'b0, 6'd45, 8'h00, d));
    apply("R9 eeorc", 2'b10, 1'b0, 6'd19, 8'hEE, d, refCalc(2'b01, 1'b0, 6'd19, 8'h00, d));

    // random vectors covering R4 R5 R6 R7 R8
    for (int i = 0; i < 400; i++) begin
      d   = {$urandom(), $urandom()};
      a   = 6'($urandom());
      imm = 8'($urandom());
      m   = 2'($urandom());
      w   = (($urandom() % 4) == 0);
      apply("R4/R5/R6 random", m, w, a, imm, d, refCalc(m, w, a, imm, d));
    end

    // R1 reset clears again mid-run
    @(negedge clk);
    rstN = 1'b0;
    #1;
    check("R1 reassert", result, 64'h0);
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule